// File: doc/BRIEF.md
# Host Command Decoder with ADC Serial Bridge

This block receives 64-bit host packets, each made of a 32-bit command word and a 32-bit data word presented together with a one-cycle valid strobe. The command word carries, from its most significant byte down, a marker byte that must equal 0xAA, a destination byte, an operation byte and a byte that must be zero. Packets for destination 0 (the main controller) with operations 5 to 8 produce a one-cycle write strobe for one of four 24-bit channel-enable registers, together with the 24-bit payload.

Packets for destinations 1 to NUM_BOARDS (receiver cards) with operation 0x80 become a 24-bit SPI write to that card's converter: an 8-bit register address in data bits 23:16 followed by 16 bits of register value in bits 15:0. The frame is shifted out MSB first on a shared clock and data line, with a per-card active-low select. While a frame is in flight the block reports busy, drops any new packet and records the loss in a sticky overrun flag.

Top module: `host_cmd_spi_bridge`

## Requirements
- R1: A packet is acted upon only when cmd_word[31:24] is 0xAA, cmd_word[7:0] is zero and data_word[31:24] is zero; any other valid packet changes no output.
- R2: With destination (cmd_word[23:16]) 0 and operation (cmd_word[15:8]) 5, 6, 7 or 8, en_we bit (operation minus 5) is high for exactly the one cycle after the strobe edge, with en_wdata equal to data_word[23:0].
- R3: With destination d in 1..NUM_BOARDS and operation 0x80, spi_cs_n bit d-1 alone goes low on the edge that samples the strobe, and the frame carries data_word[23:0].
- R4: A frame holds exactly 24 rising edges of spi_sclk, bit 23 first; spi_mosi changes only while spi_sclk falls or is low, and spi_sclk rests low outside a frame and at its end.
- R5: spi_sclk has a period of CLK_DIV system cycles, and the select stays low for 24*CLK_DIV cycles.
- R6: busy is high from the cycle after acceptance of an SPI packet until the select returns high, and falls in the same cycle as the select.
- R7: Any valid packet arriving while busy is discarded without effect and sets overrun, which stays set until reset.
- R8: Unknown operations, destinations above NUM_BOARDS, operation 0x80 to destination 0 and operations 5..8 to a receiver card produce no write strobe, no frame and no overrun.
- R9: After reset all selects are high, spi_sclk, spi_mosi, busy and overrun are low and en_we is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | One-cycle strobe qualifying the two words |
| cmd_word | input | 32 | Marker, destination, operation, zero byte |
| data_word | input | 32 | Payload word |
| en_we | output | 4 | One-hot strobe for the four enable registers |
| en_wdata | output | 24 | Payload for the strobed enable register |
| spi_cs_n | output | NUM_BOARDS | Per-card active-low select |
| spi_sclk | output | 1 | Shared serial clock |
| spi_mosi | output | 1 | Shared serial data |
| busy | output | 1 | Frame in progress |
| overrun | output | 1 | Sticky packet-dropped flag |

## Verification
A corrupted bit counter or divider shows at the ports as a frame with the wrong number of clock edges or a select held low for other than 24*CLK_DIV cycles, visible by the end of that frame. A wrong shift register content shows as a mismatched address or value at the frame end, and a stuck activity flag shows either as busy disagreeing with the select in the same cycle or as later packets being lost with overrun set. A decode fault shows one cycle after the strobe as a strobe or select on the wrong destination.

// File: rtl/host_cmd_spi_bridge.sv
module host_cmd_spi_bridge #(
  parameter int NUM_BOARDS = 12,
  parameter int CLK_DIV    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pkt_valid,
  input  logic [31:0]           cmd_word,
  input  logic [31:0]           data_word,
  output logic [3:0]            en_we,
  output logic [23:0]           en_wdata,
  output logic [NUM_BOARDS-1:0] spi_cs_n,
  output logic                  spi_sclk,
  output logic                  spi_mosi,
  output logic                  busy,
  output logic                  overrun
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [7:0] NB8 = 8'(NUM_BOARDS);
  localparam logic [CW-1:0] HLAST = CW'(HALF - 1);

  logic [7:0]            dest, op;
  logic                  frame_ok, accept, spi_go, reg_go;
  logic [NUM_BOARDS-1:0] sel;
  logic                  act;
  logic [CW-1:0]         cnt;
  logic [4:0]            bitcnt;
  logic [23:0]           sh;

  assign dest     = cmd_word[23:16];
  assign op       = cmd_word[15:8];
  assign frame_ok = (cmd_word[31:24] == 8'hAA) && (cmd_word[7:0] == 8'h00) &&
                    (data_word[31:24] == 8'h00);
  assign accept   = pkt_valid && !act && frame_ok;
  assign spi_go   = accept && (op == 8'h80) && (dest != 8'd0) && (dest <= NB8);
  assign reg_go   = accept && (dest == 8'd0) && (op >= 8'd5) && (op <= 8'd8);

  always_comb
    for (int i = 0; i < NUM_BOARDS; i++) sel[i] = (dest == 8'(i + 1));

  assign busy     = act;
  assign spi_mosi = act & sh[23];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_we    <= '0;
      en_wdata <= '0;
    end else begin
      en_we <= '0;
      if (reg_go) begin
        en_we    <= 4'b0001 << op[1:0] - 2'd1;
        en_wdata <= data_word[23:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                overrun <= 1'b0;
    else if (pkt_valid && act) overrun <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act <= 1'b0; spi_cs_n <= '1; spi_sclk <= 1'b0;
      cnt <= '0; bitcnt <= '0; sh <= '0;
    end else if (spi_go) begin
      act <= 1'b1; spi_cs_n <= ~sel; spi_sclk <= 1'b0;
      cnt <= '0; bitcnt <= '0; sh <= data_word[23:0];
    end else if (act) begin
      if (cnt == HLAST) begin
        cnt <= '0;
        if (!spi_sclk) spi_sclk <= 1'b1;
        else begin
          spi_sclk <= 1'b0;
          if (bitcnt == 5'd23) begin
            act      <= 1'b0;
            spi_cs_n <= '1;
          end else begin
            bitcnt <= bitcnt + 5'd1;
            sh     <= {sh[22:0], 1'b0};
          end
        end
      end else cnt <= cnt + CW'(1);
    end
endmodule

module host_cmd_spi_bridge_chk #(
  parameter int NUM_BOARDS = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pkt_valid,
  input logic [31:0]           cmd_word,
  input logic [31:0]           data_word,
  input logic [3:0]            en_we,
  input logic [NUM_BOARDS-1:0] spi_cs_n,
  input logic                  spi_sclk,
  input logic                  spi_mosi,
  input logic                  busy,
  input logic                  overrun
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n)); // R3
  AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_we)); // R2
  AST_BUSY_CS: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (spi_cs_n != '1)); // R6
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk); // R4
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7
  AST_BAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !busy && (cmd_word[31:24] != 8'hAA || data_word[31:24] != 8'h00))
      |=> (en_we == '0) && $stable(spi_cs_n)); // R1
endmodule

bind host_cmd_spi_bridge host_cmd_spi_bridge_chk #(.NUM_BOARDS(NUM_BOARDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .cmd_word(cmd_word),
  .data_word(data_word), .en_we(en_we), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .busy(busy), .overrun(overrun));

// File: tb/host_cmd_spi_bridge_bench.sv
module host_cmd_spi_bridge_bench;
  localparam int NB  = 12;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0;
  logic [31:0] cmd_word = '0, data_word = '0;
  logic [3:0]  en_we;
  logic [23:0] en_wdata;
  logic [NB-1:0] spi_cs_n;
  logic spi_sclk, spi_mosi, busy, overrun;

  always #5 clk = ~clk;

  host_cmd_spi_bridge #(.NUM_BOARDS(NB), .CLK_DIV(DIV)) u_host_cmd_spi_bridge (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .cmd_word(cmd_word),
    .data_word(data_word), .en_we(en_we), .en_wdata(en_wdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .busy(busy), .overrun(overrun));

  int checks = 0, fails = 0;
  int n_frames = 0, n_writes = 0;
  logic [31:0] spi_q[$];
  logic [27:0] reg_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] c, input logic [31:0] d);
    @(negedge clk);
    pkt_valid = 1'b1; cmd_word = c; data_word = d;
    @(negedge clk);
    pkt_valid = 1'b0; cmd_word = '0; data_word = '0;
  endtask

  task automatic adc_write(input int brd, input logic [7:0] addr, input logic [15:0] val);
    spi_q.push_back({8'(brd), addr, val});
    send({8'hAA, 8'(brd), 8'h80, 8'h00}, {8'h00, addr, val});
  endtask

  task automatic en_write(input int idx, input logic [23:0] val);
    reg_q.push_back({4'b0001 << idx, val});
    send({8'hAA, 8'h00, 8'(idx + 5), 8'h00}, {8'h00, val});
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk)
    if (rst_n && en_we != '0) begin
      n_writes++;
      if (reg_q.size() == 0) chk(0, "R8 unexpected enable write", en_we, 0);
      else begin
        logic [27:0] e;
        e = reg_q.pop_front();
        chk({en_we, en_wdata} == e, "R2 enable write", {en_we, en_wdata}, e);
      end
    end

  initial begin
    forever begin
      int brd, low_cyc, rises, last_rise, bad_period;
      logic [23:0] word;
      logic prev;
      @(negedge clk);
      if (rst_n && spi_cs_n != '1) begin
        brd = 0;
        for (int i = 0; i < NB; i++) if (!spi_cs_n[i]) brd = i + 1;
        low_cyc = 0; rises = 0; last_rise = 0; bad_period = 0; word = '0; prev = 1'b0;
        while (spi_cs_n != '1) begin
          low_cyc++;
          if (spi_sclk && !prev) begin
            word = {word[22:0], spi_mosi};
            if (rises > 0 && low_cyc - last_rise != DIV) bad_period = 1;
            last_rise = low_cyc;
            rises++;
          end
          prev = spi_sclk;
          @(negedge clk);
        end
        n_frames++;
        chk(rises == 24, "R4 rising edges per frame", rises, 24);
        chk(low_cyc == 24 * DIV, "R5 select low cycles", low_cyc, 24 * DIV);
        chk(bad_period == 0, "R5 sclk period", bad_period, 0);
        chk(!spi_sclk, "R4 sclk low at frame end", spi_sclk, 0);
        if (spi_q.size() == 0) chk(0, "R8 unexpected frame", brd, 0);
        else begin
          logic [31:0] e;
          e = spi_q.pop_front();
          chk({8'(brd), word} == e, "R3 frame board and word", {8'(brd), word}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == '1 && !spi_sclk && !spi_mosi && !busy && !overrun && en_we == 0,
        "R9 reset outputs", {spi_cs_n, spi_sclk, busy, overrun}, {NB{1'b1}} << 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    adc_write(1, 8'h00, 16'h0001);
    chk(busy, "R6 busy after acceptance", busy, 1);
    settle();
    adc_write(1, 8'h00, 16'h0001); settle();
    adc_write(1, 8'h11, 16'h0444); settle();
    adc_write(1, 8'h46, 16'h8204); settle();
    adc_write(1, 8'h25, 16'h0040); settle();
    adc_write(NB, 8'hA5, 16'h5AC3); settle();
    adc_write(7, 8'hFF, 16'hFFFF); settle();
    chk(!busy, "R6 busy low when idle", busy, 0);

    en_write(0, 24'hFFFFFF); en_write(1, 24'h00FFFF);
    en_write(2, 24'h123456); en_write(3, 24'hABCDEF);
    repeat (4) @(negedge clk);

    send({8'hAB, 8'd1, 8'h80, 8'h00}, 32'h0000_1234);   // R1 wrong marker
    send({8'hAA, 8'd0, 8'd5, 8'h01}, 32'h0000_1234);    // R1 nonzero low byte
    send({8'hAA, 8'd2, 8'h80, 8'h00}, 32'h0100_1234);   // R1 nonzero data top byte
    send({8'hAA, 8'd13, 8'h80, 8'h00}, 32'h0000_1234);  // R8 board out of range
    send({8'hAA, 8'd0, 8'h80, 8'h00}, 32'h0000_1234);   // R8 SPI op to main board
    send({8'hAA, 8'd1, 8'd5, 8'h00}, 32'h0000_1234);    // R8 enable op to card
    send({8'hAA, 8'd0, 8'd9, 8'h00}, 32'h0000_1234);    // R8 unknown op
    send({8'hAA, 8'd0, 8'd4, 8'h00}, 32'h0000_1234);    // R8 unknown op
    repeat (30) @(negedge clk);
    chk(!busy && spi_cs_n == '1, "R1 R8 ignored packets leave SPI idle", busy, 0);
    chk(!overrun, "R8 no overrun from ignored packets", overrun, 0);
    chk(n_frames == 7, "R8 frame count", n_frames, 7);
    chk(n_writes == 4, "R8 write count", n_writes, 4);

    adc_write(2, 8'h3C, 16'hC3C3);
    send({8'hAA, 8'd0, 8'd6, 8'h00}, 32'h0000_0F0F);    // R7 dropped
    send({8'hAA, 8'd3, 8'h80, 8'h00}, 32'h0000_7777);   // R7 dropped
    @(negedge clk);
    chk(overrun, "R7 overrun set", overrun, 1);
    settle();
    chk(n_frames == 8 && n_writes == 4, "R7 dropped packets had no effect",
        n_frames * 16 + n_writes, 8 * 16 + 4);
    adc_write(4, 8'h01, 16'h0002); settle();
    chk(overrun, "R7 overrun sticky", overrun, 1);
    chk(spi_q.size() == 0 && reg_q.size() == 0, "R3 all expected items seen",
        spi_q.size() + reg_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule